// File: doc/BRIEF.md
# Static Branch Resolution Unit

This block decides conditional branches that the instruction queue offers from its lower half. For each offered branch it checks whether an integer or floating-point instruction still in flight is going to write the condition bit. If no such write is pending, the branch is decided at once from the current condition value. If a write is pending, the unit guesses the outcome from the sign of the branch displacement and keeps that guess until the condition bit settles. A software control input can invert the direction rule.

When the unit decides that a branch is taken, or guesses that it is, it asks the prefetcher to refill the queue behind the branch from the target address. While a guess is open, the unit marks younger instructions as conditional, and their register writeback is held back. When the condition bit settles, a correct guess produces a single commit pulse. A wrong guess produces a squash, which flushes the queue and all pipelines, together with a redirect to the address where execution should restart.

Top module: `sbr_unit`

## Requirements
- R1: A branch is accepted (`br_take_o` high in the same cycle) only when `br_valid_i` is high and `br_slot_i` is below QDEPTH/2, which is the lower half of the queue. A branch in an upper slot leaves every output unchanged.
- R2: If both busy inputs are low when a branch is accepted, the branch is decided immediately. In the next cycle, `redir_o` is high exactly when `cond_i` equals `br_sense_i`, and `spec_o` stays low.
- R3: If either busy input is high when a branch is accepted, `spec_o` goes high in the next cycle. With `pred_flip_i` low, a negative displacement is guessed taken (`redir_o` high in that cycle) and a non-negative one is guessed not taken (`redir_o` low).
- R4: With `pred_flip_i` high, the guess is inverted: a backward branch is guessed not taken and a forward branch is guessed taken.
- R5: The target address is `br_pc_i` plus the sign-extended byte displacement `br_disp_i`. The fall-through address is `br_pc_i` plus INSN_BYTES. Every redirect to the target carries this target on `redir_addr_o`.
- R6: `spec_o` stays high from the cycle after a speculative accept until the cycle after the first cycle in which both busy inputs are low. While it is high, younger instructions are conditional and their writeback is held.
- R7: If the settled outcome (`cond_i == sense`) matches the guess, `commit_o` pulses for one cycle, in the same cycle that `spec_o` falls, and neither `squash_o` nor `redir_o` is raised.
- R8: If the settled outcome differs from the guess, `squash_o` and `redir_o` pulse together. `redir_addr_o` is the target when the branch is actually taken and the fall-through address when it is not.
- R9: While `spec_o` is high, or in a squash cycle, no further branch is accepted, so the next branch stalls in the queue.
- R10: After reset, `br_take_o`, `redir_o`, `spec_o`, `commit_o` and `squash_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| br_valid_i | input | 1 | Queue offers a conditional branch |
| br_slot_i | input | SLOT_W | Queue slot that holds the offered branch |
| br_pc_i | input | ADDR_W | Address of the branch |
| br_disp_i | input | DISP_W | Signed byte displacement |
| br_sense_i | input | 1 | Condition value for which the branch is taken |
| cond_i | input | 1 | Current condition bit |
| int_cr_busy_i | input | 1 | An in-flight integer op will write the condition bit |
| fp_cr_busy_i | input | 1 | An in-flight floating-point op will write the condition bit |
| pred_flip_i | input | 1 | Software control that inverts the direction rule |
| br_take_o | output | 1 | Branch accepted and removed from the queue |
| redir_o | output | 1 | Fetch redirect request |
| redir_addr_o | output | ADDR_W | Redirect address |
| spec_o | output | 1 | Younger instructions are conditional and writeback is held |
| commit_o | output | 1 | Guess confirmed, so held writebacks are released |
| squash_o | output | 1 | Guess wrong, so the queue and pipelines are flushed |

## Verification
The bench builds the unit with its defaults: an 8-entry queue, 32-bit addresses and a 16-bit displacement. With these values, slot 3 is the last slot accepted and slot 4 or 5 is refused, so the half-queue boundary is reachable. The 16-bit displacement makes the most negative value 0x8000 practical to exercise, which checks sign extension across the upper address bits. The short queue and narrow fields also let every combination of busy source, branch sense, direction and override appear in a handful of directed scenarios, including both kinds of misprediction with their two distinct restart addresses.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  // Bookkeeping for the single open guess
  typedef struct packed {
    logic        pred_taken;
    logic        sense;
  } guess_t;
endpackage

// File: rtl/sbr_target.sv
module sbr_target #(
  parameter int ADDR_W     = 32,
  parameter int DISP_W     = 16,
  parameter int INSN_BYTES = 4
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] target_o,
  output logic [ADDR_W-1:0] fall_o,
  output logic              backward_o
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    end else begin : g_trunc
      assign disp_ext = disp_i[ADDR_W-1:0];
    end
  endgenerate

  assign target_o   = pc_i + disp_ext;
  assign fall_o     = pc_i + ADDR_W'(INSN_BYTES);
  assign backward_o = disp_i[DISP_W-1];
endmodule

// File: rtl/sbr_accept.sv
module sbr_accept #(
  parameter int QDEPTH = 8,
  parameter int SLOT_W = 3
) (
  input  logic              valid_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              spec_i,
  input  logic              squash_i,
  input  logic              backward_i,
  input  logic              flip_i,
  output logic              take_o,
  output logic              pred_taken_o
);
  localparam int HALF = QDEPTH / 2;

  logic in_low_half;

  assign in_low_half  = (32'(slot_i) < HALF);
  assign take_o       = valid_i & in_low_half & ~spec_i & ~squash_i;
  assign pred_taken_o = backward_i ^ flip_i;
endmodule

// File: rtl/sbr_ctrl.sv
module sbr_ctrl
  import sbr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              busy_i,
  input  logic              cond_i,
  input  logic              sense_i,
  input  logic              pred_taken_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic [ADDR_W-1:0] fall_i,
  output logic              spec_o,
  output logic              redir_o,
  output logic [ADDR_W-1:0] redir_addr_o,
  output logic              commit_o,
  output logic              squash_o
);
  guess_t            guess_q, guess_d;
  logic [ADDR_W-1:0] tgt_q, fall_q;
  logic              spec_q, spec_d;
  logic              redir_q, redir_d;
  logic [ADDR_W-1:0] raddr_q, raddr_d;
  logic              commit_q, commit_d;
  logic              squash_q, squash_d;
  logic              hold_en;
  logic              resolve;
  logic              actual;

  assign hold_en = take_i & busy_i;
  assign resolve = spec_q & ~busy_i;
  assign actual  = (cond_i == guess_q.sense);

  always_comb begin
    spec_d   = spec_q;
    redir_d  = 1'b0;
    raddr_d  = raddr_q;
    commit_d = 1'b0;
    squash_d = 1'b0;
    guess_d  = '{pred_taken: pred_taken_i, sense: sense_i};
    if (take_i) begin
      raddr_d = target_i;
      if (busy_i) begin
        spec_d  = 1'b1;
        redir_d = pred_taken_i;
      end else begin
        redir_d = (cond_i == sense_i);
      end
    end else if (resolve) begin
      spec_d   = 1'b0;
      commit_d = (actual == guess_q.pred_taken);
      squash_d = (actual != guess_q.pred_taken);
      redir_d  = (actual != guess_q.pred_taken);
      raddr_d  = actual ? tgt_q : fall_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spec_q   <= 1'b0;
      redir_q  <= 1'b0;
      raddr_q  <= '0;
      commit_q <= 1'b0;
      squash_q <= 1'b0;
    end else begin
      spec_q   <= spec_d;
      redir_q  <= redir_d;
      raddr_q  <= raddr_d;
      commit_q <= commit_d;
      squash_q <= squash_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guess_q <= '0;
      tgt_q   <= '0;
      fall_q  <= '0;
    end else if (hold_en) begin
      guess_q <= guess_d;
      tgt_q   <= target_i;
      fall_q  <= fall_i;
    end
  end

  assign spec_o       = spec_q;
  assign redir_o      = redir_q;
  assign redir_addr_o = raddr_q;
  assign commit_o     = commit_q;
  assign squash_o     = squash_q;
endmodule

// File: rtl/sbr_unit.sv
module sbr_unit #(
  parameter int QDEPTH     = 8,
  parameter int ADDR_W     = 32,
  parameter int DISP_W     = 16,
  parameter int INSN_BYTES = 4,
  parameter int SLOT_W     = $clog2(QDEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid_i,
  input  logic [SLOT_W-1:0] br_slot_i,
  input  logic [ADDR_W-1:0] br_pc_i,
  input  logic [DISP_W-1:0] br_disp_i,
  input  logic              br_sense_i,
  input  logic              cond_i,
  input  logic              int_cr_busy_i,
  input  logic              fp_cr_busy_i,
  input  logic              pred_flip_i,
  output logic              br_take_o,
  output logic              redir_o,
  output logic [ADDR_W-1:0] redir_addr_o,
  output logic              spec_o,
  output logic              commit_o,
  output logic              squash_o
);
  logic              rst_meta_q, rst_sync_n;
  logic [ADDR_W-1:0] target, fall;
  logic              backward, pred_taken, busy;

  // Reset asserts at once and releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign busy = int_cr_busy_i | fp_cr_busy_i;

  sbr_target #(
    .ADDR_W(ADDR_W), .DISP_W(DISP_W), .INSN_BYTES(INSN_BYTES)
  ) u_target (
    .pc_i(br_pc_i), .disp_i(br_disp_i),
    .target_o(target), .fall_o(fall), .backward_o(backward)
  );

  sbr_accept #(.QDEPTH(QDEPTH), .SLOT_W(SLOT_W)) u_accept (
    .valid_i(br_valid_i & rst_sync_n), .slot_i(br_slot_i),
    .spec_i(spec_o), .squash_i(squash_o),
    .backward_i(backward), .flip_i(pred_flip_i),
    .take_o(br_take_o), .pred_taken_o(pred_taken)
  );

  sbr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .take_i(br_take_o), .busy_i(busy), .cond_i(cond_i),
    .sense_i(br_sense_i), .pred_taken_i(pred_taken),
    .target_i(target), .fall_i(fall),
    .spec_o(spec_o), .redir_o(redir_o), .redir_addr_o(redir_addr_o),
    .commit_o(commit_o), .squash_o(squash_o)
  );
endmodule

// File: rtl/sbr_unit_chk.sv
module sbr_unit_chk #(
  parameter int QDEPTH = 8,
  parameter int SLOT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              br_valid_i,
  input logic [SLOT_W-1:0] br_slot_i,
  input logic              br_take_o,
  input logic              redir_o,
  input logic              spec_o,
  input logic              commit_o,
  input logic              squash_o
);
  // R1
  low_half_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_take_o |-> (br_valid_i && (32'(br_slot_i) < QDEPTH / 2)));
  // R9
  stall_while_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_o || squash_o) |-> !br_take_o);
  // R7
  single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit_o, squash_o}));
  // R8
  squash_redirects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash_o |-> redir_o);
  // R6
  spec_from_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spec_o && br_take_o) |=> (spec_o || !commit_o));
  // R7
  commit_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_o || squash_o) |-> !spec_o);
endmodule

bind sbr_unit sbr_unit_chk #(.QDEPTH(QDEPTH), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .br_valid_i(br_valid_i), .br_slot_i(br_slot_i), .br_take_o(br_take_o),
  .redir_o(redir_o), .spec_o(spec_o), .commit_o(commit_o), .squash_o(squash_o)
);

// File: tb/test_sbr_unit.sv
module test_sbr_unit;
  localparam int ADDR_W = 32;
  localparam int DISP_W = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              br_valid_i;
  logic [2:0]        br_slot_i;
  logic [ADDR_W-1:0] br_pc_i;
  logic [DISP_W-1:0] br_disp_i;
  logic              br_sense_i, cond_i, int_cr_busy_i, fp_cr_busy_i, pred_flip_i;
  logic              br_take_o, redir_o, spec_o, commit_o, squash_o;
  logic [ADDR_W-1:0] redir_addr_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sbr_unit i_sbr_unit (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
    chk(act === exp, req, what, act, exp);
  endtask

  // Offer one branch at a negedge, sample the accept, return at the next negedge
  task automatic offer(input logic [2:0] slot, input logic [31:0] pc,
                       input logic [15:0] disp, input logic sense,
                       output logic took);
    @(negedge clk);
    br_valid_i = 1'b1; br_slot_i = slot; br_pc_i = pc;
    br_disp_i = disp; br_sense_i = sense;
    #1 took = br_take_o;
    @(negedge clk);
    br_valid_i = 1'b0;
  endtask

  // Release the busy inputs with a settled condition, return once outcome is visible
  task automatic settle(input logic c);
    cond_i = c; int_cr_busy_i = 1'b0; fp_cr_busy_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk_eq("R10", "take", br_take_o, 1'b0);
    chk_eq("R10", "redir", redir_o, 1'b0);
    chk_eq("R10", "spec", spec_o, 1'b0);
    chk_eq("R10", "commit", commit_o, 1'b0);
    chk_eq("R10", "squash", squash_o, 1'b0);
  endtask

  task automatic t_upper_half;
    logic took;
    cond_i = 1'b1;
    offer(3'd4, 32'h100, 16'h10, 1'b1, took);
    chk_eq("R1", "slot4 take", took, 1'b0);
    chk_eq("R1", "slot4 redir", redir_o, 1'b0);
    offer(3'd5, 32'h100, 16'h10, 1'b1, took);
    chk_eq("R1", "slot5 take", took, 1'b0);
    chk_eq("R1", "slot5 spec", spec_o, 1'b0);
  endtask

  task automatic t_immediate;
    logic took;
    cond_i = 1'b1;
    offer(3'd3, 32'h1000, 16'h0040, 1'b1, took);
    chk_eq("R1", "slot3 take", took, 1'b1);
    chk_eq("R2", "imm taken redir", redir_o, 1'b1);
    chk_eq("R5", "imm target", redir_addr_o, 32'h1040);
    chk_eq("R2", "imm spec", spec_o, 1'b0);
    cond_i = 1'b0;
    offer(3'd0, 32'h1000, 16'h0040, 1'b1, took);
    chk_eq("R2", "imm not taken", redir_o, 1'b0);
    offer(3'd1, 32'h1200, 16'hFFF0, 1'b0, took);
    chk_eq("R2", "sense0 taken", redir_o, 1'b1);
    chk_eq("R5", "sense0 target", redir_addr_o, 32'h11F0);
  endtask

  task automatic t_back_commit;
    logic took;
    pred_flip_i = 1'b0; int_cr_busy_i = 1'b1;
    offer(3'd2, 32'h0001_0000, 16'h8000, 1'b1, took);
    chk_eq("R3", "spec set", spec_o, 1'b1);
    chk_eq("R3", "backward guessed taken", redir_o, 1'b1);
    chk_eq("R5", "most negative target", redir_addr_o, 32'h0000_8000);
    offer(3'd0, 32'h500, 16'h4, 1'b1, took);
    chk_eq("R9", "second branch stalls", took, 1'b0);
    chk_eq("R6", "spec held while busy", spec_o, 1'b1);
    settle(1'b1);
    chk_eq("R7", "commit", commit_o, 1'b1);
    chk_eq("R7", "no squash", squash_o, 1'b0);
    chk_eq("R7", "no redir", redir_o, 1'b0);
    chk_eq("R6", "spec cleared", spec_o, 1'b0);
    @(negedge clk);
    chk_eq("R7", "commit one pulse", commit_o, 1'b0);
  endtask

  task automatic t_fwd_squash;
    logic took;
    pred_flip_i = 1'b0; fp_cr_busy_i = 1'b1;
    offer(3'd1, 32'h3000, 16'h0080, 1'b1, took);
    chk_eq("R3", "forward spec", spec_o, 1'b1);
    chk_eq("R3", "forward guessed not taken", redir_o, 1'b0);
    settle(1'b1);
    chk_eq("R8", "squash", squash_o, 1'b1);
    chk_eq("R8", "squash redir", redir_o, 1'b1);
    chk_eq("R8", "restart at target", redir_addr_o, 32'h3080);
    chk_eq("R8", "no commit", commit_o, 1'b0);
  endtask

  task automatic t_flip;
    logic took;
    @(negedge clk);
    pred_flip_i = 1'b1; int_cr_busy_i = 1'b1;
    offer(3'd0, 32'h4000, 16'hFF00, 1'b1, took);
    chk_eq("R4", "flipped backward not taken", redir_o, 1'b0);
    chk_eq("R4", "flipped spec", spec_o, 1'b1);
    settle(1'b0);
    chk_eq("R4", "flipped backward commit", commit_o, 1'b1);
    fp_cr_busy_i = 1'b1;
    offer(3'd3, 32'h5000, 16'h0100, 1'b0, took);
    chk_eq("R4", "flipped forward taken", redir_o, 1'b1);
    chk_eq("R5", "flipped forward target", redir_addr_o, 32'h5100);
    settle(1'b1);
    chk_eq("R8", "squash to fall-through", squash_o, 1'b1);
    chk_eq("R8", "fall-through addr", redir_addr_o, 32'h5004);
    pred_flip_i = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; br_valid_i = 1'b0; br_slot_i = '0; br_pc_i = '0; br_disp_i = '0;
    br_sense_i = 1'b0; cond_i = 1'b0; int_cr_busy_i = 1'b0; fp_cr_busy_i = 1'b0;
    pred_flip_i = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_upper_half();
    t_immediate();
    t_back_commit();
    t_fwd_squash();
    t_flip();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule